// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block forms the 16-bit product of two 8-bit unsigned numbers over several clock cycles, using one 8-bit adder and one double-width product register. A one-cycle start pulse captures the multiplicand into a holding register. In the same edge it clears the upper half of the product register and loads the multiplier into the lower half. Each following cycle inspects the lowest bit of the product register. When that bit is set, the multiplicand is added into the upper half. The whole register then moves right by one place, and the adder's carry enters at the top.

Because the multiplier bits are consumed from the bottom of the product register as partial-product bits enter from the top, no separate multiplier register is needed. A 3-bit iteration counter with an all-ones terminal condition ends the run after eight steps. A one-cycle done pulse then marks the product as valid. The product holds its value until a new operation is accepted. The adder is a chain of 4-bit slices.

Top module: `shift_add_mul`

## Requirements
- R1: While rst is high at a rising edge, and after it, the block is idle: product reads 0 and done is 0. A reset during an operation abandons it, and no done pulse follows for that operation.
- R2: When start is high at a rising edge while idle, opA and opB are sampled at that edge. After that edge, product reads {8'h00, opB}. Later changes on opA and opB do not affect the result.
- R3: done is high for exactly one cycle. It begins at the 8th rising edge after the edge that accepted start. At that point, product equals opA*opB of the accepted operation.
- R4: The adder carry enters bit 15 on each step, so every operand pair up to 255*255 = 65025 gives the exact 16-bit product.
- R5: A start pulse while an operation is running is ignored. The running operation completes with unchanged timing and result, and no extra done pulse occurs.
- R6: While idle and with no start, product stays stable at its last value.
- R7: A start in the cycle in which done is high is accepted. The new operation's done follows 8 edges later, and the new operands replace the previous product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication |
| opA | input | 8 | Multiplicand |
| opB | input | 8 | Multiplier |
| product | output | 16 | Product register contents |
| done | output | 1 | One-cycle pulse: product is valid |

## Verification
The done pulse of one operation and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising start at the very sample where it observes done. The scoreboard then expects the earlier product in that cycle, a fresh done exactly eight edges later, and the new product at that point. A start raised during a running operation is also driven, and it is judged by the unchanged timing of the pending result and by the absence of any extra done pulse.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } samCtrl_t;
endpackage

// File: rtl/sam_nibble_add.sv
module sam_nibble_add #(
  parameter int SLICE = 4
) (
  input  logic [SLICE-1:0] inX,
  input  logic [SLICE-1:0] inY,
  input  logic             carryIn,
  output logic [SLICE-1:0] sumOut,
  output logic             carryOut
);
  logic [SLICE:0] wide;
  assign wide     = {1'b0, inX} + {1'b0, inY} + {{SLICE{1'b0}}, carryIn};
  assign sumOut   = wide[SLICE-1:0];
  assign carryOut = wide[SLICE];
endmodule

// File: rtl/sam_adder.sv
module sam_adder #(
  parameter int WIDTH = 8,
  parameter int SLICE = 4
) (
  input  logic [WIDTH-1:0] addX,
  input  logic [WIDTH-1:0] addY,
  output logic [WIDTH-1:0] addSum,
  output logic             addCarry
);
  localparam int NSLICE = WIDTH / SLICE;
  logic [NSLICE:0] chain;
  assign chain[0] = 1'b0;

  for (genvar s = 0; s < NSLICE; s++) begin : gSlice
    sam_nibble_add #(.SLICE(SLICE)) uSlice (
      .inX     (addX[s*SLICE +: SLICE]),
      .inY     (addY[s*SLICE +: SLICE]),
      .carryIn (chain[s]),
      .sumOut  (addSum[s*SLICE +: SLICE]),
      .carryOut(chain[s+1])
    );
  end
  assign addCarry = chain[NSLICE];
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath
  import sam_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SLICE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  samCtrl_t         ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcandReg;
  logic [PW-1:0]    prodReg;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] partSum;
  logic             partCarry;

  assign addend = prodReg[0] ? mcandReg : '0;

  sam_adder #(.WIDTH(WIDTH), .SLICE(SLICE)) uAdd (
    .addX    (prodReg[PW-1:WIDTH]),
    .addY    (addend),
    .addSum  (partSum),
    .addCarry(partCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prodReg  <= '0;
      mcandReg <= '0;
    end else if (ctrl.load) begin
      prodReg  <= {{WIDTH{1'b0}}, opB};
      mcandReg <= opA;
    end else if (ctrl.step) begin
      prodReg <= {partCarry, partSum, prodReg[WIDTH-1:1]};
    end
  end

  assign product = prodReg;

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.load |=> prodReg == {{WIDTH{1'b0}}, $past(opB)});

  // R4
  step_arith_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.step |=>
      (prodReg[PW-1:WIDTH-1] ==
        ((WIDTH+1)'($past(prodReg[PW-1:WIDTH])) +
         (WIDTH+1)'($past(prodReg[0]) ? $past(mcandReg) : '0)))
      && (prodReg[WIDTH-2:0] == $past(prodReg[WIDTH-1:1])));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.load && !ctrl.step) |=> $stable(prodReg));
endmodule

// File: rtl/sam_control.sv
module sam_control
  import sam_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  output samCtrl_t ctrl,
  output logic     done
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic          busy;
  logic [CW-1:0] iterCnt;
  logic          lastIter;

  assign lastIter  = (iterCnt == LAST);
  assign ctrl.load = start && !busy;
  assign ctrl.step = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= busy && lastIter;
      if (ctrl.load) begin
        busy    <= 1'b1;
        iterCnt <= '0;
      end else if (busy) begin
        iterCnt <= iterCnt + 1'b1;
        if (lastIter) busy <= 1'b0;
      end
    end
  end

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !lastIter) |=> busy && (iterCnt == $past(iterCnt) + 1'b1));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul
  import sam_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SLICE = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);
  samCtrl_t ctrl;

  sam_control #(.WIDTH(WIDTH)) uCtrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .ctrl (ctrl),
    .done (done)
  );

  sam_datapath #(.WIDTH(WIDTH), .SLICE(SLICE)) uData (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .opA    (opA),
    .opB    (opB),
    .product(product)
  );
endmodule

// File: tb/shift_add_mul_test.sv
`timescale 1ns/1ps
module shift_add_mul_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opA = '0;
  logic [7:0]  opB = '0;
  logic [15:0] product;
  logic        done;

  shift_add_mul uut (
    .clk(clk), .rst(rst), .start(start),
    .opA(opA), .opB(opB), .product(product), .done(done)
  );

  always #10 clk = ~clk;

  typedef struct { logic [15:0] prod; int cyc; } expItem_t;
  expItem_t expQ[$];
  int cyc = 0;
  int errors = 0;
  int checks = 0;
  logic prevDone = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        check(!prevDone, "R3", "done wider than one cycle", 1, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R5", "done with no pending operation", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(product == e.prod, "R3", "product", product, e.prod);
          check(cyc == e.cyc, "R3", "done timing", cyc, e.cyc);
        end
      end
      prevDone <= done;
    end else begin
      prevDone <= 1'b0;
    end
  end

  // called at a falling edge; start is taken at the next rising edge
  task automatic issue(input logic [7:0] a, input logic [7:0] b);
    expItem_t e;
    opA = a; opB = b; start = 1'b1;
    e.prod = 16'(a) * 16'(b);
    e.cyc  = cyc + 9;
    expQ.push_back(e);
    @(negedge clk);
    start = 1'b0;
    check(product == {8'h00, b}, "R2", "load value", product, {8'h00, b});
    opA = ~a; opB = ~b;   // R2: later input changes must not matter
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic [7:0] pa, pb;
    repeat (3) @(negedge clk);
    check(product == 0, "R1", "product in reset", product, 0);
    check(done == 0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 and R4: assorted operand patterns, including the full-scale carry case
    issue(8'd255, 8'd255); waitDone(); @(negedge clk);
    issue(8'd0,   8'd0);   waitDone(); @(negedge clk);
    issue(8'd1,   8'd255); waitDone(); @(negedge clk);
    issue(8'd255, 8'd0);   waitDone(); @(negedge clk);
    issue(8'd128, 8'd2);   waitDone(); @(negedge clk);
    issue(8'd200, 8'd3);   waitDone(); @(negedge clk);
    pa = 8'd37; pb = 8'd91;
    for (int i = 0; i < 6; i++) begin
      issue(pa, pb); waitDone(); @(negedge clk);
      pa = pa * 8'd29 + 8'd11;
      pb = pb * 8'd53 + 8'd7;
    end

    // R6: product held while idle
    issue(8'd13, 8'd11); waitDone();
    held = product;
    repeat (6) @(negedge clk);
    check(product == held, "R6", "product held idle", product, held);
    check(product == 16'd143, "R6", "held value", product, 143);
    check(done == 0, "R6", "done stays low idle", done, 0);

    // R7: new start in the cycle where done is high
    issue(8'd99, 8'd77); waitDone();
    issue(8'd250, 8'd6); waitDone();
    issue(8'd17, 8'd255); waitDone();
    @(negedge clk);
    check(done == 0, "R7", "done low after chain", done, 0);
    check(product == 16'd4335, "R7", "last chained product", product, 4335);

    // R5: start during a running operation is ignored
    issue(8'd45, 8'd201);
    repeat (3) @(negedge clk);
    opA = 8'd7; opB = 8'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    repeat (12) @(negedge clk);
    check(expQ.size() == 0, "R5", "pending operations", expQ.size(), 0);
    check(product == 16'd9045, "R5", "result kept", product, 9045);

    // R1: reset during an operation abandons it
    issue(8'd60, 8'd60);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    expQ.delete();
    rst = 1'b0;
    check(product == 0, "R1", "product after mid-run reset", product, 0);
    check(done == 0, "R1", "done after mid-run reset", done, 0);
    repeat (14) @(negedge clk);
    check(expQ.size() == 0, "R1", "no stray result", expQ.size(), 0);
    check(product == 0, "R1", "product idle after reset", product, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule